// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives one DRAM bank. It accepts one read or write request at a time. Each request carries a row, a column, a write flag and a hint that a later request to the same row is already waiting. The block turns the request into the commands the bank needs and places them on a command output bus. It keeps a record of whether the bank's row buffer holds an open row and which row that is. From that record it sorts each request into one of three cases: a hit on the open row, an access to a closed bank, or a conflict with a different open row.

Every command waits until the minimum cycle gap since the command that limits it has passed. Four limits apply: activate to activate, activate to column, precharge to activate, and write to read. A compile-time switch picks the row buffer policy. Under the open policy the row stays open after each access. Under the closed policy the row is precharged right after the column command, unless the request's same-row hint is set.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, and the bank counts as closed, so the first request gets an activate with no precharge before it.
- R2: Command encoding on cmd_op, valid only while cmd_valid is 1: 0 = activate, 1 = read, 2 = write, 3 = precharge. cmd_row carries the row for an activate or a precharge. cmd_col carries the column for a read or a write.
- R3: A request to the row that is open produces exactly one column command (read or write), with no activate and no precharge.
- R4: A request to a closed bank produces an activate of the requested row, followed by the column command.
- R5: A request to a row other than the open one produces three commands in order: a precharge of the open row, an activate of the new row, then the column command.
- R6: Under the open policy the row stays open after every access, whatever the same-row hint says.
- R7: Under the closed policy a precharge of the accessed row follows the column command, unless the request's same-row hint was 1. In that case the row stays open.
- R8: Two activates are never closer than T_RC cycles.
- R9: A read is never issued fewer than T_WTR cycles after a write.
- R10: A column command comes at least T_RCD cycles after the activate that opened its row. An activate comes at least T_RP cycles after the preceding precharge. On a closed bank with no other limit pending, the column command comes exactly T_RCD cycles after the activate.
- R11: req_ready falls in the cycle after a request is accepted. It rises again only once the column command has been issued and, under the closed policy, the closing precharge as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_same_row_next | input | 1 | A later request to the same row is waiting |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_row | output | ROW_W | Row for activate and precharge |
| cmd_col | output | COL_W | Column for read and write |

## Verification
The bench drives two instances, one with each policy, through sequences that reach all three access classes in turn. An activate-then-read sequence on a fresh bank separates a closed-bank access from a hit. A second access to the same row checks that no activate is issued. A new row then forces the precharge-activate-column chain of a conflict. A write followed at once by a read of the open row shows that the write-to-read gap holds the read back. On the closed-policy instance the same row is accessed with and without the hint, which tells an automatic close apart from a kept row. A scan of every logged command then checks all four minimum gaps across both instances.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Command codes presented on cmd_op
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } dram_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ACT   = 3'd2,
        ST_COL   = 3'd3,
        ST_CLOSE = 3'd4
    } seq_state_e;

    // Classification of an incoming request against the row buffer
    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } access_kind_e;

    // Index of each gap timer
    localparam int unsigned GAP_NUM = 4;
    localparam int unsigned GAP_RC  = 0;
    localparam int unsigned GAP_RCD = 1;
    localparam int unsigned GAP_RP  = 2;
    localparam int unsigned GAP_WTR = 3;

endpackage

// File: rtl/bseq_gap_timer.sv
// Down-counter that enforces a minimum spacing. A start loads GAP-1. The
// dependent command may be decided once the count is zero, which places it
// GAP cycles after the starting command on the registered command bus.
module bseq_gap_timer #(
    parameter int unsigned GAP   = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(GAP - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bseq_row_classify.sv
// Sorts an incoming row against the row buffer state.
module bseq_row_classify
    import bseq_pkg::*;
#(
    parameter int unsigned ROW_W = 14
) (
    input  logic             open_vld,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    output access_kind_e     kind
);
    always_comb begin
        if (!open_vld) begin
            kind = ACC_EMPTY;
        end else if (open_row == req_row) begin
            kind = ACC_HIT;
        end else begin
            kind = ACC_CONFLICT;
        end
    end
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
    import bseq_pkg::*;
#(
    parameter int unsigned ROW_W       = 14,
    parameter int unsigned COL_W       = 10,
    parameter int unsigned T_RC        = 8,
    parameter int unsigned T_RCD       = 3,
    parameter int unsigned T_RP        = 3,
    parameter int unsigned T_WTR       = 4,
    parameter bit          CLOSED_PAGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic             req_same_row_next,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col
);
    localparam int unsigned GAP_MAX_A = (T_RC > T_RCD) ? T_RC : T_RCD;
    localparam int unsigned GAP_MAX_B = (T_RP > T_WTR) ? T_RP : T_WTR;
    localparam int unsigned GAP_MAX   = (GAP_MAX_A > GAP_MAX_B) ? GAP_MAX_A : GAP_MAX_B;
    localparam int unsigned CNT_W     = $clog2(GAP_MAX + 1);
    localparam int unsigned GAP_LOAD [GAP_NUM] = '{T_RC, T_RCD, T_RP, T_WTR};

    typedef struct packed {
        seq_state_e       st;
        logic             open_vld;
        logic [ROW_W-1:0] open_row;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic             keep;
        logic             cmd_vld;
        dram_op_e         cmd_op;
        logic [ROW_W-1:0] cmd_row;
        logic [COL_W-1:0] cmd_col;
    } seq_regs_t;

    seq_regs_t          r_d, r_q;
    access_kind_e       kind;
    logic [GAP_NUM-1:0] gap_start;
    logic [GAP_NUM-1:0] gap_ok;
    logic               auto_close;

    bseq_row_classify #(.ROW_W(ROW_W)) u_classify (
        .open_vld (r_q.open_vld),
        .open_row (r_q.open_row),
        .req_row  (req_row),
        .kind     (kind)
    );

    for (genvar g = 0; g < GAP_NUM; g++) begin : g_gap
        bseq_gap_timer #(
            .GAP   (GAP_LOAD[g]),
            .CNT_W (CNT_W)
        ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (gap_start[g]),
            .expired (gap_ok[g])
        );
    end

    // Row buffer policy: whether a column command is followed by a close
    if (CLOSED_PAGE) begin : g_closed_page
        assign auto_close = ~r_q.keep;
    end else begin : g_open_page
        assign auto_close = 1'b0;
    end

    always_comb begin
        r_d         = r_q;
        r_d.cmd_vld = 1'b0;
        gap_start   = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.row  = req_row;
                    r_d.col  = req_col;
                    r_d.wr   = req_write;
                    r_d.keep = req_same_row_next;
                    unique case (kind)
                        ACC_HIT:      r_d.st = ST_COL;
                        ACC_EMPTY:    r_d.st = ST_ACT;
                        default:      r_d.st = ST_PRE;
                    endcase
                end
            end

            ST_PRE: begin
                r_d.cmd_vld        = 1'b1;
                r_d.cmd_op         = OP_PRE;
                r_d.cmd_row        = r_q.open_row;
                r_d.open_vld       = 1'b0;
                gap_start[GAP_RP]  = 1'b1;
                r_d.st             = ST_ACT;
            end

            ST_ACT: begin
                if (gap_ok[GAP_RC] && gap_ok[GAP_RP]) begin
                    r_d.cmd_vld        = 1'b1;
                    r_d.cmd_op         = OP_ACT;
                    r_d.cmd_row        = r_q.row;
                    r_d.open_vld       = 1'b1;
                    r_d.open_row       = r_q.row;
                    gap_start[GAP_RC]  = 1'b1;
                    gap_start[GAP_RCD] = 1'b1;
                    r_d.st             = ST_COL;
                end
            end

            ST_COL: begin
                if (gap_ok[GAP_RCD] && (r_q.wr || gap_ok[GAP_WTR])) begin
                    r_d.cmd_vld        = 1'b1;
                    r_d.cmd_op         = r_q.wr ? OP_WR : OP_RD;
                    r_d.cmd_col        = r_q.col;
                    gap_start[GAP_WTR] = r_q.wr;
                    r_d.st             = auto_close ? ST_CLOSE : ST_IDLE;
                end
            end

            ST_CLOSE: begin
                r_d.cmd_vld       = 1'b1;
                r_d.cmd_op        = OP_PRE;
                r_d.cmd_row       = r_q.open_row;
                r_d.open_vld      = 1'b0;
                gap_start[GAP_RP] = 1'b1;
                r_d.st            = ST_IDLE;
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.open_vld <= 1'b0;
            r_q.open_row <= '0;
            r_q.row      <= '0;
            r_q.col      <= '0;
            r_q.wr       <= 1'b0;
            r_q.keep     <= 1'b0;
            r_q.cmd_vld  <= 1'b0;
            r_q.cmd_op   <= OP_ACT;
            r_q.cmd_row  <= '0;
            r_q.cmd_col  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign cmd_valid = r_q.cmd_vld;
    assign cmd_op    = r_q.cmd_op;
    assign cmd_row   = r_q.cmd_row;
    assign cmd_col   = r_q.cmd_col;
endmodule

// File: rtl/bseq_check.sv
// Port-level protocol checker, attached to every bank_cmd_seq instance.
module bseq_check #(
    parameter int unsigned T_RC  = 8,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_WTR = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       cmd_valid,
    input logic [1:0] cmd_op
);
    localparam int unsigned SAT = 32'h4000_0000;

    int unsigned since_act_q, since_pre_q, since_wr_q;
    logic        open_q;
    logic        is_act, is_rd, is_wr, is_pre;

    assign is_act = cmd_valid && (cmd_op == 2'd0);
    assign is_rd  = cmd_valid && (cmd_op == 2'd1);
    assign is_wr  = cmd_valid && (cmd_op == 2'd2);
    assign is_pre = cmd_valid && (cmd_op == 2'd3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act_q <= SAT;
            since_pre_q <= SAT;
            since_wr_q  <= SAT;
            open_q      <= 1'b0;
        end else begin
            since_act_q <= is_act ? 1 : ((since_act_q < SAT) ? since_act_q + 1 : SAT);
            since_pre_q <= is_pre ? 1 : ((since_pre_q < SAT) ? since_pre_q + 1 : SAT);
            since_wr_q  <= is_wr  ? 1 : ((since_wr_q  < SAT) ? since_wr_q  + 1 : SAT);
            if (is_act) open_q <= 1'b1;
            else if (is_pre) open_q <= 1'b0;
        end
    end

    assert_act_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_act_q >= T_RC));
    assert_wtr_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (since_wr_q >= T_WTR));
    assert_rcd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_act_q >= T_RCD));
    assert_rp_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_pre_q >= T_RP));
    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !open_q);
    assert_col_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> open_q);
    assert_pre_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> open_q);
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind bank_cmd_seq bseq_check #(
    .T_RC  (T_RC),
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_WTR (T_WTR)
) u_bseq_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op)
);

// File: tb/tb_bank_cmd_seq.sv
module tb_bank_cmd_seq;
    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int T_RC  = 8;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_WTR = 4;
    localparam int LOGN  = 64;
    localparam logic [1:0] K_ACT = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_PRE = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    // index 0: open policy (dut), index 1: closed policy (dut_cl)
    logic             req_valid [2];
    logic             req_ready [2];
    logic [ROW_W-1:0] req_row   [2];
    logic [COL_W-1:0] req_col   [2];
    logic             req_write [2];
    logic             req_hint  [2];
    logic             cmd_valid [2];
    logic [1:0]       cmd_op    [2];
    logic [ROW_W-1:0] cmd_row   [2];
    logic [COL_W-1:0] cmd_col   [2];

    bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC), .T_RCD(T_RCD),
                   .T_RP(T_RP), .T_WTR(T_WTR), .CLOSED_PAGE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
        .req_row(req_row[0]), .req_col(req_col[0]), .req_write(req_write[0]),
        .req_same_row_next(req_hint[0]), .cmd_valid(cmd_valid[0]), .cmd_op(cmd_op[0]),
        .cmd_row(cmd_row[0]), .cmd_col(cmd_col[0]));

    bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC), .T_RCD(T_RCD),
                   .T_RP(T_RP), .T_WTR(T_WTR), .CLOSED_PAGE(1'b1)) dut_cl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
        .req_row(req_row[1]), .req_col(req_col[1]), .req_write(req_write[1]),
        .req_same_row_next(req_hint[1]), .cmd_valid(cmd_valid[1]), .cmd_op(cmd_op[1]),
        .cmd_row(cmd_row[1]), .cmd_col(cmd_col[1]));

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    int n_log  [2];
    logic [1:0] op_log  [2][LOGN];
    int         cyc_log [2][LOGN];
    int         fld_log [2][LOGN];

    always @(posedge clk) cycle <= cycle + 1;

    // Command monitor, away from the active edge
    always @(negedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (rst_n && cmd_valid[u] && n_log[u] < LOGN) begin
                op_log[u][n_log[u]]  <= cmd_op[u];
                cyc_log[u][n_log[u]] <= cycle;
                fld_log[u][n_log[u]] <= (cmd_op[u] == K_ACT || cmd_op[u] == K_PRE) ?
                                        int'(cmd_row[u]) : int'(cmd_col[u]);
                n_log[u]             <= n_log[u] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_cmd(input int u, input int idx, input logic [1:0] op,
                             input int fld, input string req);
        check(idx < n_log[u], {req, " command present"}, n_log[u], idx + 1);
        if (idx < n_log[u]) begin
            check(op_log[u][idx] == op, {req, " opcode"}, int'(op_log[u][idx]), int'(op));
            check(fld_log[u][idx] == fld, {req, " address field"}, fld_log[u][idx], fld);
        end
    endtask

    // One request; returns log index of its first command and the count it produced
    task automatic run_req(input int u, input int row, input int col, input bit wr,
                           input bit hint, output int first, output int cnt);
        first = n_log[u];
        @(negedge clk);
        while (!req_ready[u]) @(negedge clk);
        req_valid[u] = 1'b1;
        req_row[u]   = ROW_W'(row);
        req_col[u]   = COL_W'(col);
        req_write[u] = wr;
        req_hint[u]  = hint;
        @(negedge clk);
        req_valid[u] = 1'b0;
        check(req_ready[u] == 1'b0, "R11 busy after accept", int'(req_ready[u]), 0);
        while (!req_ready[u]) @(negedge clk);
        #2;
        cnt = n_log[u] - first;
    endtask

    task automatic t_reset();
        check(req_ready[0] && req_ready[1], "R1 ready after reset",
              int'(req_ready[0]) + int'(req_ready[1]), 2);
        check(!cmd_valid[0] && !cmd_valid[1], "R1 no command after reset",
              int'(cmd_valid[0]) + int'(cmd_valid[1]), 0);
    endtask

    task automatic t_open_closed_bank();
        int f, c;
        run_req(0, 5, 1, 1'b0, 1'b0, f, c);
        check(c == 2, "R4 closed-bank command count", c, 2);
        check_cmd(0, f, K_ACT, 5, "R1 R4 activate first");
        check_cmd(0, f + 1, K_RD, 1, "R2 R4 read");
        check(cyc_log[0][f+1] - cyc_log[0][f] == T_RCD, "R10 activate-to-read",
              cyc_log[0][f+1] - cyc_log[0][f], T_RCD);
    endtask

    task automatic t_open_hit_write();
        int f, c;
        run_req(0, 5, 2, 1'b1, 1'b0, f, c);
        check(c == 1, "R3 R6 hit command count", c, 1);
        check_cmd(0, f, K_WR, 2, "R2 R3 write on hit");
    endtask

    task automatic t_open_write_read();
        int f, c, wcyc;
        wcyc = cyc_log[0][n_log[0]-1];
        run_req(0, 5, 3, 1'b0, 1'b0, f, c);
        check(c == 1, "R3 read hit count", c, 1);
        check_cmd(0, f, K_RD, 3, "R3 read on hit");
        check(cyc_log[0][f] - wcyc == T_WTR, "R9 write-to-read held back",
              cyc_log[0][f] - wcyc, T_WTR);
    endtask

    task automatic t_open_conflict();
        int f, c;
        run_req(0, 9, 4, 1'b0, 1'b0, f, c);
        check(c == 3, "R5 conflict command count", c, 3);
        check_cmd(0, f, K_PRE, 5, "R5 precharge old row");
        check_cmd(0, f + 1, K_ACT, 9, "R5 activate new row");
        check_cmd(0, f + 2, K_RD, 4, "R5 read");
    endtask

    task automatic t_closed_autoclose();
        int f, c;
        run_req(1, 3, 0, 1'b0, 1'b0, f, c);
        check(c == 3, "R7 auto close command count", c, 3);
        check_cmd(1, f, K_ACT, 3, "R7 activate");
        check_cmd(1, f + 1, K_RD, 0, "R7 read");
        check_cmd(1, f + 2, K_PRE, 3, "R7 closing precharge");
    endtask

    task automatic t_closed_keep();
        int f, c;
        run_req(1, 3, 1, 1'b1, 1'b1, f, c);
        check(c == 2, "R7 hint keeps row count", c, 2);
        check_cmd(1, f, K_ACT, 3, "R7 R4 activate");
        check_cmd(1, f + 1, K_WR, 1, "R7 write");
        run_req(1, 3, 2, 1'b0, 1'b0, f, c);
        check(c == 2, "R7 R3 hit then close count", c, 2);
        check_cmd(1, f, K_RD, 2, "R3 read on kept row");
        check_cmd(1, f + 1, K_PRE, 3, "R7 close after hit");
    endtask

    task automatic t_gap_scan(input int u);
        int last_act, last_pre, last_wr;
        last_act = -1000; last_pre = -1000; last_wr = -1000;
        for (int i = 0; i < n_log[u]; i++) begin
            int cy;
            cy = cyc_log[u][i];
            if (op_log[u][i] == K_ACT) begin
                check(cy - last_act >= T_RC, "R8 activate spacing", cy - last_act, T_RC);
                check(cy - last_pre >= T_RP, "R10 precharge-to-activate", cy - last_pre, T_RP);
                last_act = cy;
            end else if (op_log[u][i] == K_PRE) begin
                last_pre = cy;
            end else begin
                check(cy - last_act >= T_RCD, "R10 activate-to-column", cy - last_act, T_RCD);
                if (op_log[u][i] == K_RD)
                    check(cy - last_wr >= T_WTR, "R9 write-to-read spacing", cy - last_wr, T_WTR);
                else
                    last_wr = cy;
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        for (int u = 0; u < 2; u++) begin
            n_log[u] = 0;
            req_valid[u] = 1'b0;
            req_row[u] = '0;
            req_col[u] = '0;
            req_write[u] = 1'b0;
            req_hint[u] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_closed_bank();
        t_open_hit_write();
        t_open_write_read();
        t_open_conflict();
        t_closed_autoclose();
        t_closed_keep();
        t_gap_scan(0);
        t_gap_scan(1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycle, 0);
        finish_run();
    end
endmodule